// File: doc/BRIEF.md
# UDP Receive Packet Buffer

This block sits between a network stack's UDP receive path and user logic. It holds received packets in two queues until user logic reads them. Each packet enters as one header beat (destination port, source node, source port, byte length) followed by 64-bit payload beats. The header goes into a header queue and the payload beats go into a payload queue.

The block decides whether to keep a packet when its header arrives. It drops the packet if the source node is not a known cluster node. It also drops the packet if either queue lacks room for the whole packet. A kept packet is stored completely, and a dropped one is never stored in part. The beats of a dropped packet are still consumed from the input so that the stream stays aligned.

Packets that are already queued are always delivered. Each packet appears on the output as one metadata beat, which always carries the length, followed by its payload beats, the last of which is flagged. Two saturating counters record packets dropped for lack of space and packets dropped for an unknown source.

Top module: `udp_rxq`

## Requirements
- R1: After reset, `out_meta_valid` and `out_dat_valid` are 0, both counters are 0, `in_hdr_ready` is 1 and `in_dat_ready` is 0.
- R2: A packet from a known source (`in_hdr_src_node` < NODE_COUNT, default 64) with length L bytes takes ceil(L/8) input beats. It is delivered with identical header fields, and its beats come out in order with the data, keep and last values as given.
- R3: A packet whose source node is NODE_COUNT or above is dropped whole. Its beats are consumed, `mismatch_count` rises by 1, `drop_count` is unchanged and nothing reaches the output.
- R4: A packet from a known source whose word count ceil(L/8) exceeds the free payload words is dropped whole. Its beats are consumed and `drop_count` rises by 1.
- R5: A packet arriving while the header queue holds HDR_DEPTH entries is dropped whole and `drop_count` rises by 1.
- R6: A packet whose word count exactly equals the free payload words is admitted.
- R7: Packets queued before a drop are delivered intact and in arrival order after it.
- R8: `out_dat_valid` stays 0 until the packet's metadata beat has been accepted. The next packet's metadata is not offered until the last beat of the current packet has been read.
- R9: With SATURATE=1, each counter stops at its all-ones value of CNT_W bits and does not wrap.
- R10: While a packet's payload is being taken in, `in_hdr_ready` is 0 and `in_dat_ready` is 1. Once its last beat is taken, `in_hdr_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_hdr_valid | input | 1 | Incoming header valid |
| in_hdr_ready | output | 1 | Header accepted this cycle when valid |
| in_hdr_dst_port | input | 16 | Destination UDP port |
| in_hdr_src_node | input | 8 | Source node id |
| in_hdr_src_port | input | 16 | Source UDP port |
| in_hdr_len | input | 16 | Payload length in bytes (nonzero) |
| in_dat_valid | input | 1 | Incoming payload beat valid |
| in_dat_ready | output | 1 | Payload beat accepted when valid |
| in_dat_data | input | 64 | Payload data |
| in_dat_keep | input | 8 | Byte enables |
| in_dat_last | input | 1 | Final beat of packet |
| out_meta_valid | output | 1 | Metadata beat valid |
| out_meta_ready | input | 1 | User logic takes metadata |
| out_meta_dst_port | output | 16 | Destination port |
| out_meta_src_node | output | 8 | Source node id |
| out_meta_src_port | output | 16 | Source port |
| out_meta_len | output | 16 | Length in bytes |
| out_dat_valid | output | 1 | Payload beat valid |
| out_dat_ready | input | 1 | User logic takes payload beat |
| out_dat_data | output | 64 | Payload data |
| out_dat_keep | output | 8 | Byte enables |
| out_dat_last | output | 1 | Final beat of packet |
| drop_count | output | CNT_W | Packets dropped for lack of space |
| mismatch_count | output | CNT_W | Packets dropped for unknown source |

## Verification
The bench runs with a 16-word payload queue and a 3-entry header queue, so that both limits can be reached quickly. Single packets with partial and full last beats show that fields, data and keep pass through unchanged. Two packets that exactly fill the payload queue, followed by a one-word packet, separate the exact-fit case from the overflow case. Four one-beat packets isolate header-queue exhaustion, since their payload uses only a few words. A run of unknown-source packets drives the mismatch counter past its limit and confirms that the two drop causes are counted apart.

// File: rtl/udp_rxq_pkg.sv
`timescale 1ns/1ps
package udp_rxq_pkg;
   localparam int PORT_W = 16;
   localparam int NODE_W = 8;
   localparam int LEN_W  = 16;

   typedef struct packed {
      logic [PORT_W-1:0] dst_port;
      logic [NODE_W-1:0] src_node;
      logic [PORT_W-1:0] src_port;
      logic [LEN_W-1:0]  len;
   } rxq_hdr_t;

   localparam int HDR_W = $bits(rxq_hdr_t);
endpackage

// File: rtl/rxq_fifo.sv
`timescale 1ns/1ps
module rxq_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 4,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic [CW-1:0]    count,
   output logic             full,
   output logic             empty
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rxq_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;

   function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
      return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
   endfunction

   assign full  = (32'(count) == DEPTH);
   assign empty = (count == '0);
   assign dout  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= nxt(wr_ptr);
         if (pop)  rd_ptr <= nxt(rd_ptr);
         if (push && !pop)      count <= count + 1'b1;
         else if (pop && !push) count <= count - 1'b1;
      end
   end

   // R4 / R5: admission must never push into a full queue
   a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   // R7: readers only pop stored entries
   a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/rxq_counter.sv
`timescale 1ns/1ps
module rxq_counter #(
   parameter int W        = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] value
);
   generate
      if (W < 1) begin : g_bad_w
         $error("rxq_counter: W must be positive");
      end
      if (SATURATE) begin : g_sat
         always_ff @(posedge clk) begin
            if (!rst_n)                 value <= '0;
            else if (inc && !(&value))  value <= value + 1'b1;
         end
         // R9: a saturating count never goes down
         a_r9_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> value >= $past(value));
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n)   value <= '0;
            else if (inc) value <= value + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/rxq_admit.sv
`timescale 1ns/1ps
module rxq_admit
   import udp_rxq_pkg::*;
#(
   parameter int NODE_COUNT = 64,
   parameter int PAY_CW     = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hdr_valid,
   input  rxq_hdr_t          hdr,
   output logic              hdr_ready,
   input  logic              dat_valid,
   input  logic              dat_last,
   output logic              dat_ready,
   input  logic [PAY_CW-1:0] pay_free,
   input  logic              hdr_full,
   output logic              hdr_push,
   output logic              pay_push,
   output logic              drop_inc,
   output logic              mismatch_inc
);
   logic        busy, keep_pkt;
   logic        hdr_fire, known, fits;
   logic [31:0] need_words;

   assign hdr_ready  = !busy;
   assign dat_ready  = busy;
   assign hdr_fire   = hdr_valid && !busy;
   assign need_words = (32'(hdr.len) + 32'd7) >> 3;
   assign known      = (32'(hdr.src_node) < NODE_COUNT);
   assign fits       = !hdr_full && (need_words <= 32'(pay_free));

   assign hdr_push     = hdr_fire && known && fits;
   assign mismatch_inc = hdr_fire && !known;
   assign drop_inc     = hdr_fire && known && !fits;
   assign pay_push     = busy && dat_valid && keep_pkt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         keep_pkt <= 1'b0;
      end else if (hdr_fire) begin
         busy     <= 1'b1;
         keep_pkt <= known && fits;
      end else if (busy && dat_valid && dat_last) begin
         busy     <= 1'b0;
      end
   end

   // R10: after the final payload beat the next header may enter
   a_r10_hdr_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_ready && dat_valid && dat_last) |=> hdr_ready);
endmodule

// File: rtl/udp_rxq.sv
`timescale 1ns/1ps
module udp_rxq
   import udp_rxq_pkg::*;
#(
   parameter int PAY_DEPTH  = 2304,
   parameter int HDR_DEPTH  = 98,
   parameter int NODE_COUNT = 64,
   parameter int DATA_W     = 64,
   parameter int CNT_W      = 32,
   parameter bit SATURATE   = 1'b1,
   localparam int KEEP_W    = DATA_W / 8,
   localparam int PAY_W     = DATA_W + KEEP_W + 1,
   localparam int PAY_CW    = $clog2(PAY_DEPTH + 1),
   localparam int HDR_CW    = $clog2(HDR_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_hdr_valid,
   output logic              in_hdr_ready,
   input  logic [PORT_W-1:0] in_hdr_dst_port,
   input  logic [NODE_W-1:0] in_hdr_src_node,
   input  logic [PORT_W-1:0] in_hdr_src_port,
   input  logic [LEN_W-1:0]  in_hdr_len,
   input  logic              in_dat_valid,
   output logic              in_dat_ready,
   input  logic [DATA_W-1:0] in_dat_data,
   input  logic [KEEP_W-1:0] in_dat_keep,
   input  logic              in_dat_last,
   output logic              out_meta_valid,
   input  logic              out_meta_ready,
   output logic [PORT_W-1:0] out_meta_dst_port,
   output logic [NODE_W-1:0] out_meta_src_node,
   output logic [PORT_W-1:0] out_meta_src_port,
   output logic [LEN_W-1:0]  out_meta_len,
   output logic              out_dat_valid,
   input  logic              out_dat_ready,
   output logic [DATA_W-1:0] out_dat_data,
   output logic [KEEP_W-1:0] out_dat_keep,
   output logic              out_dat_last,
   output logic [CNT_W-1:0]  drop_count,
   output logic [CNT_W-1:0]  mismatch_count
);
   generate
      if (DATA_W % 8 != 0) begin : g_bad_data_w
         $error("udp_rxq: DATA_W must be a whole number of bytes");
      end
      if (DATA_W != 64) begin : g_bad_beat
         $error("udp_rxq: length-to-word conversion assumes 8-byte beats");
      end
   endgenerate

   rxq_hdr_t          in_hdr, head_hdr;
   logic              hdr_push, hdr_pop, hdr_full, hdr_empty;
   logic [HDR_CW-1:0] hdr_count;
   logic              pay_push, pay_pop, pay_full, pay_empty;
   logic [PAY_CW-1:0] pay_count, pay_free;
   logic [PAY_W-1:0]  pay_head;
   logic              drop_inc, mismatch_inc;
   logic              meta_taken;

   assign in_hdr = '{dst_port: in_hdr_dst_port, src_node: in_hdr_src_node,
                     src_port: in_hdr_src_port, len: in_hdr_len};
   assign pay_free = PAY_CW'(PAY_DEPTH) - pay_count;

   rxq_admit #(.NODE_COUNT(NODE_COUNT), .PAY_CW(PAY_CW)) u_admit (
      .clk(clk), .rst_n(rst_n),
      .hdr_valid(in_hdr_valid), .hdr(in_hdr), .hdr_ready(in_hdr_ready),
      .dat_valid(in_dat_valid), .dat_last(in_dat_last), .dat_ready(in_dat_ready),
      .pay_free(pay_free), .hdr_full(hdr_full),
      .hdr_push(hdr_push), .pay_push(pay_push),
      .drop_inc(drop_inc), .mismatch_inc(mismatch_inc));

   rxq_fifo #(.WIDTH(HDR_W), .DEPTH(HDR_DEPTH)) u_hdr_q (
      .clk(clk), .rst_n(rst_n), .push(hdr_push), .din(in_hdr),
      .pop(hdr_pop), .dout(head_hdr), .count(hdr_count),
      .full(hdr_full), .empty(hdr_empty));

   rxq_fifo #(.WIDTH(PAY_W), .DEPTH(PAY_DEPTH)) u_pay_q (
      .clk(clk), .rst_n(rst_n), .push(pay_push),
      .din({in_dat_keep, in_dat_last, in_dat_data}),
      .pop(pay_pop), .dout(pay_head), .count(pay_count),
      .full(pay_full), .empty(pay_empty));

   rxq_counter #(.W(CNT_W), .SATURATE(SATURATE)) u_drop_cnt (
      .clk(clk), .rst_n(rst_n), .inc(drop_inc), .value(drop_count));

   rxq_counter #(.W(CNT_W), .SATURATE(SATURATE)) u_mis_cnt (
      .clk(clk), .rst_n(rst_n), .inc(mismatch_inc), .value(mismatch_count));

   // read side: metadata first, then payload, header retired on last beat
   assign out_meta_valid    = !hdr_empty && !meta_taken;
   assign out_meta_dst_port = head_hdr.dst_port;
   assign out_meta_src_node = head_hdr.src_node;
   assign out_meta_src_port = head_hdr.src_port;
   assign out_meta_len      = head_hdr.len;

   assign out_dat_valid = !pay_empty && meta_taken;
   assign {out_dat_keep, out_dat_last, out_dat_data} = pay_head;
   assign pay_pop = out_dat_valid && out_dat_ready;
   assign hdr_pop = pay_pop && out_dat_last;

   always_ff @(posedge clk) begin
      if (!rst_n)                                  meta_taken <= 1'b0;
      else if (hdr_pop)                            meta_taken <= 1'b0;
      else if (out_meta_valid && out_meta_ready)   meta_taken <= 1'b1;
   end

   // R8: a payload beat is only offered while its header is still queued
   a_r8_payload_has_header: assert property (@(posedge clk) disable iff (!rst_n)
      out_dat_valid |-> !hdr_empty);
   // R2: payload words never exceed what the header queue accounts for
   a_r2_payload_needs_header: assert property (@(posedge clk) disable iff (!rst_n)
      !pay_empty |-> (hdr_count != '0));
endmodule

// File: tb/sim_udp_rxq.sv
`timescale 1ns/1ps
module sim_udp_rxq;
   localparam int PAY_DEPTH = 16;
   localparam int HDR_DEPTH = 3;
   localparam int CNT_W     = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_hdr_valid = 1'b0, in_hdr_ready;
   logic [15:0] in_hdr_dst_port = '0, in_hdr_src_port = '0, in_hdr_len = '0;
   logic [7:0]  in_hdr_src_node = '0;
   logic        in_dat_valid = 1'b0, in_dat_ready, in_dat_last = 1'b0;
   logic [63:0] in_dat_data = '0;
   logic [7:0]  in_dat_keep = '0;
   logic        out_meta_valid, out_meta_ready = 1'b0;
   logic [15:0] out_meta_dst_port, out_meta_src_port, out_meta_len;
   logic [7:0]  out_meta_src_node;
   logic        out_dat_valid, out_dat_ready = 1'b0, out_dat_last;
   logic [63:0] out_dat_data;
   logic [7:0]  out_dat_keep;
   logic [CNT_W-1:0] drop_count, mismatch_count;

   int nchk = 0, nfail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   udp_rxq #(.PAY_DEPTH(PAY_DEPTH), .HDR_DEPTH(HDR_DEPTH), .NODE_COUNT(64),
             .DATA_W(64), .CNT_W(CNT_W), .SATURATE(1'b1)) u0 (.*);

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] beat_data(input int seed, input int i);
      return {16'hC0DE, 16'(seed), 16'(seed * 3), 16'(i)};
   endfunction

   function automatic logic [7:0] beat_keep(input int len, input int i);
      int n = (len + 7) / 8;
      int r = len % 8;
      if (i == n - 1 && r != 0) return 8'((1 << r) - 1);
      return 8'hFF;
   endfunction

   task automatic send_pkt(input int node, input int len, input int seed);
      int n = (len + 7) / 8;
      @(negedge clk);
      in_hdr_valid = 1'b1;
      in_hdr_dst_port = 16'(2718 + seed);
      in_hdr_src_node = 8'(node);
      in_hdr_src_port = 16'(3000 + seed);
      in_hdr_len = 16'(len);
      while (!in_hdr_ready) @(negedge clk);
      @(negedge clk);
      in_hdr_valid = 1'b0;
      chk("R10", "hdr_ready during payload", in_hdr_ready, 0);
      chk("R10", "dat_ready during payload", in_dat_ready, 1);
      for (int i = 0; i < n; i++) begin
         in_dat_valid = 1'b1;
         in_dat_data = beat_data(seed, i);
         in_dat_keep = beat_keep(len, i);
         in_dat_last = (i == n - 1);
         while (!in_dat_ready) @(negedge clk);
         @(negedge clk);
      end
      in_dat_valid = 1'b0;
      in_dat_last = 1'b0;
   endtask

   task automatic recv_pkt(input int node, input int len, input int seed);
      int n = (len + 7) / 8;
      @(negedge clk);
      out_meta_ready = 1'b1;
      while (!out_meta_valid) @(negedge clk);
      chk("R8", "data before meta", out_dat_valid, 0);
      chk("R2", "dst_port", out_meta_dst_port, 2718 + seed);
      chk("R2", "src_node", out_meta_src_node, node);
      chk("R2", "src_port", out_meta_src_port, 3000 + seed);
      chk("R2", "len", out_meta_len, len);
      @(negedge clk);
      out_meta_ready = 1'b0;
      chk("R8", "meta held during payload", out_meta_valid, 0);
      out_dat_ready = 1'b1;
      for (int i = 0; i < n; i++) begin
         while (!out_dat_valid) @(negedge clk);
         chk("R2", "data ok", out_dat_data == beat_data(seed, i), 1);
         chk("R2", "keep", out_dat_keep, beat_keep(len, i));
         chk("R2", "last", out_dat_last, (i == n - 1));
         @(negedge clk);
      end
      out_dat_ready = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "meta_valid", out_meta_valid, 0);
      chk("R1", "dat_valid", out_dat_valid, 0);
      chk("R1", "drop_count", drop_count, 0);
      chk("R1", "mismatch_count", mismatch_count, 0);
      chk("R1", "hdr_ready", in_hdr_ready, 1);
      chk("R1", "dat_ready", in_dat_ready, 0);
   endtask

   task automatic t_single();
      send_pkt(5, 20, 1);
      chk("R10", "hdr_ready after last", in_hdr_ready, 1);
      recv_pkt(5, 20, 1);
      send_pkt(63, 8, 2);
      recv_pkt(63, 8, 2);
   endtask

   task automatic t_unknown();
      send_pkt(64, 16, 3);
      repeat (2) @(negedge clk);
      chk("R3", "mismatch_count", mismatch_count, 1);
      chk("R3", "drop_count", drop_count, 0);
      chk("R3", "nothing delivered", out_meta_valid, 0);
   endtask

   task automatic t_payload_full();
      send_pkt(1, 64, 4);
      send_pkt(2, 57, 5);
      repeat (2) @(negedge clk);
      chk("R6", "exact fit not dropped", drop_count, 0);
      send_pkt(3, 8, 6);
      repeat (2) @(negedge clk);
      chk("R4", "overflow drop_count", drop_count, 1);
      recv_pkt(1, 64, 4);
      recv_pkt(2, 57, 5);
      repeat (2) @(negedge clk);
      chk("R4", "dropped packet absent", out_meta_valid, 0);
   endtask

   task automatic t_header_full();
      send_pkt(7, 8, 7);
      send_pkt(8, 3, 8);
      send_pkt(9, 8, 9);
      send_pkt(10, 8, 10);
      repeat (2) @(negedge clk);
      chk("R5", "header full drop_count", drop_count, 2);
      chk("R5", "mismatch unchanged", mismatch_count, 1);
      recv_pkt(7, 8, 7);
      recv_pkt(8, 3, 8);
      recv_pkt(9, 8, 9);
      repeat (2) @(negedge clk);
      chk("R7", "queue drained", out_meta_valid, 0);
   endtask

   task automatic t_saturate();
      for (int k = 0; k < 16; k++) send_pkt(200, 8, 11);
      repeat (2) @(negedge clk);
      chk("R9", "mismatch saturates", mismatch_count, 15);
      chk("R9", "drop_count unchanged", drop_count, 2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_unknown();
      t_payload_full();
      t_header_full();
      t_saturate();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end
endmodule